// File: doc/BRIEF.md
# SPI Host Controller with Register Bus

This block is a memory-mapped SPI master. A processor reaches it through a simple 32-bit register bus. The bus has a one-cycle write strobe, a read strobe and a read-data path that returns data in the same cycle. Behind the bus sit a transmit queue, a receive queue, an active-low slave-select register, a control register for the clock and bit-order options, and an interrupt unit with per-event status and enable bits and one global gate.

Software parks the shift engine with a hold bit, loads the transmit queue, and then clears the hold bit. The engine pops the queued words one after another and shifts them out on SCLK/MOSI. At the same time it samples MISO into the receive queue. When the last queued word has fully left the shifter, an event bit is latched so the processor knows the burst is over. The serial clock runs at a fixed fraction of the system clock, set by a build parameter. The word width is also fixed at build time.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the control register reads 0x180 (hold and manual-select set), status reads 0x05, slave select reads all ones, `irq` is low and SCLK rests at 0.
- R2: No SCLK edge occurs while control bit 8 (hold) is set, or while bit 1 (enable) or bit 2 (master) is clear, even with words queued. Clearing the hold starts the transfer, which takes 2×WORD_W SCLK edges per word.
- R3: SCLK idles at the level of control bit 3. With control bit 4 clear, MISO is sampled and MOSI must be valid on the first (leading) edge of each bit. With bit 4 set, this happens on the second (trailing) edge. Each received word is placed in the receive queue, which is popped by reading offset 0x6C.
- R4: Bits go most significant first, and the first wire bit lands in the received word's MSB. With control bit 9 set, the least significant bit goes first and lands in the LSB.
- R5: With control bit 0 set, the receiver takes the outgoing MOSI bit internally, and the MISO pin has no effect on received data.
- R6: Status at 0x64 reads bit0 receive empty, bit1 receive full, bit2 transmit empty and bit3 transmit full. Bit4 (fault) reads 0.
- R7: Event bit 2 (transmit done) latches one cycle after the final SCLK edge of a word, and only when no queued word follows. It does not latch while held words remain.
- R8: A write to offset 0x68 with the transmit queue full is dropped and latches event bit 3. A received word that meets a full receive queue is dropped and latches bit 5. Bit 4 latches when the receive queue fills. Bit 6 latches when a pop leaves the transmit queue half full.
- R9: Event bits at 0x20 clear when a one is written to them. Enables are at 0x28. `irq` is high only when bit 31 of 0x1C is set and an enabled event bit is pending.
- R10: Slave select at 0x70 is active low, one bit per slave. With control bit 7 set, it drives `ss_n` directly. With bit 7 clear, `ss_n` shows the register only while a word is in flight and is all ones otherwise.
- R11: Writing control bit 5 or bit 6 empties the transmit or receive queue. Both bits read back as 0.
- R12: Writing 0x0A to offset 0x40 returns the whole core to its reset state. Any other value written there is ignored.
- R13: Queued words go out back to back in write order and are received in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Slave selects, active low |

## Verification
A register write takes effect at the next clock edge, and a read returns its value in the same cycle. The bench therefore drives the bus on the falling edge and samples read data before the following rising edge. A released word starts one cycle after the hold bit clears, and it produces an SCLK edge every CLK_DIV cycles. The done event is due one cycle after the final edge. The bench counts SCLK edges and checks `irq` low at the first falling clock after the last edge and high at the next one. A bench-side slave captures MOSI as it was before each sampling edge and presents MISO right after that edge, so the check holds for all four clock modes and both bit orders.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_GATE  = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_EVT   = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_EVEN  = 8'h28;
    localparam logic [BUS_AW-1:0] OFS_KILL  = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h60;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 8'h64;
    localparam logic [BUS_AW-1:0] OFS_TXQ   = 8'h68;
    localparam logic [BUS_AW-1:0] OFS_RXQ   = 8'h6C;
    localparam logic [BUS_AW-1:0] OFS_SEL   = 8'h70;

    localparam logic [31:0] KILL_KEY = 32'h0000_000A;

    localparam int EV_W      = 7;
    localparam int EV_DONE   = 2;
    localparam int EV_TXDROP = 3;
    localparam int EV_RXFULL = 4;
    localparam int EV_RXDROP = 5;
    localparam int EV_TXHALF = 6;

    typedef struct packed {
        logic lsb_first;
        logic hold;
        logic manual_sel;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loop;
    } ctrl_t;

    localparam ctrl_t CTRL_INIT = '{lsb_first: 1'b0, hold: 1'b1, manual_sel: 1'b1,
                                    cpha: 1'b0, cpol: 1'b0, master: 1'b0,
                                    enable: 1'b0, loop: 1'b0};
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } qptr_t;

    qptr_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (s_q.cnt != FULL_CNT) && !clear;
        do_pop  = pop && (s_q.cnt != '0);
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = s_q.wp + 1'b1;
            if (do_pop)  s_d.rp = s_q.rp + 1'b1;
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= din;
    end

    assign dout  = mem_q[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == FULL_CNT);
    assign count = s_q.cnt;
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int W       = 8,
    parameter int CLK_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         allow,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         loop,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_word,
    output logic         tx_pop,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         word_done,
    output logic [W-1:0] rx_word
);
    localparam int EW = $clog2(2*W);
    localparam int DW = $clog2(CLK_DIV+1);
    localparam logic [DW-1:0] DIV_LAST  = DW'(CLK_DIV-1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(2*W-1);

    typedef struct packed {
        logic          active;
        logic          ph;
        logic [DW-1:0] div;
        logic [EW-1:0] edge_n;
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
        logic          done;
        logic [W-1:0]  rxo;
    } shf_t;

    shf_t s_d, s_q;
    logic out_bit, in_bit, sample;
    logic [W-1:0] rx_next;

    always_comb begin
        out_bit = lsb_first ? s_q.tx[0] : s_q.tx[W-1];
        in_bit  = loop ? out_bit : miso;
        sample  = (s_q.edge_n[0] == cpha);
        rx_next = lsb_first ? {in_bit, s_q.rx[W-1:1]} : {s_q.rx[W-2:0], in_bit};
        s_d      = s_q;
        s_d.done = 1'b0;
        tx_pop   = 1'b0;
        if (!s_q.active) begin
            if (allow && tx_avail) begin
                tx_pop     = 1'b1;
                s_d.active = 1'b1;
                s_d.tx     = tx_word;
                s_d.div    = '0;
                s_d.edge_n = '0;
                s_d.ph     = 1'b0;
            end
        end else if (s_q.div == DIV_LAST) begin
            s_d.div    = '0;
            s_d.ph     = ~s_q.ph;
            s_d.edge_n = s_q.edge_n + 1'b1;
            if (sample) begin
                s_d.rx = rx_next;
            end else if (s_q.edge_n != '0) begin
                s_d.tx = lsb_first ? {1'b0, s_q.tx[W-1:1]} : {s_q.tx[W-2:0], 1'b0};
            end
            if (s_q.edge_n == EDGE_LAST) begin
                s_d.done   = 1'b1;
                s_d.rxo    = sample ? rx_next : s_q.rx;
                s_d.edge_n = '0;
                if (allow && tx_avail) begin
                    tx_pop = 1'b1;
                    s_d.tx = tx_word;
                end else begin
                    s_d.active = 1'b0;
                end
            end
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
        if (clear) begin
            s_d    = '0;
            tx_pop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk      = cpol ^ s_q.ph;
    assign mosi      = out_bit;
    assign busy      = s_q.active;
    assign word_done = s_q.done;
    assign rx_word   = s_q.rxo;
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spim_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int DEPTH   = 16,
    parameter int CLK_DIV = 2,
    parameter int NUM_SS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CNT_NEAR_FULL = CW'(DEPTH-1);
    localparam logic [CW-1:0] CNT_HALF_UP   = CW'(DEPTH/2+1);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [NUM_SS-1:0] sel;
        logic              gate;
        logic [EV_W-1:0]   en;
        logic [EV_W-1:0]   evt;
    } regs_t;

    localparam regs_t REGS_INIT = '{ctrl: CTRL_INIT, sel: '1, gate: 1'b0, en: '0, evt: '0};

    regs_t r_d, r_q;

    logic              kill, txq_clr, rxq_clr, txq_push, rxq_pop;
    logic              txq_empty, txq_full, rxq_empty, rxq_full;
    logic [CW-1:0]     txq_cnt, rxq_cnt;
    logic [WORD_W-1:0] txq_dout, rxq_dout, sh_rx;
    logic              sh_pop, sh_busy, sh_done, allow;
    logic [EV_W-1:0]   ev, ev_clr;
    logic              hold_q, cpol_q, manual_q;

    assign hold_q   = r_q.ctrl.hold;
    assign cpol_q   = r_q.ctrl.cpol;
    assign manual_q = r_q.ctrl.manual_sel;
    assign allow    = r_q.ctrl.enable && r_q.ctrl.master && !hold_q;

    always_comb begin
        r_d      = r_q;
        kill     = 1'b0;
        txq_clr  = 1'b0;
        rxq_clr  = 1'b0;
        txq_push = 1'b0;
        rxq_pop  = bus_rd && (bus_addr == OFS_RXQ);
        ev       = '0;
        ev[EV_DONE]   = sh_done && !sh_busy && txq_empty;
        ev[EV_TXDROP] = bus_wr && (bus_addr == OFS_TXQ) && txq_full;
        ev[EV_RXFULL] = sh_done && (rxq_cnt == CNT_NEAR_FULL);
        ev[EV_RXDROP] = sh_done && rxq_full;
        ev[EV_TXHALF] = sh_pop && (txq_cnt == CNT_HALF_UP);
        ev_clr   = (bus_wr && (bus_addr == OFS_EVT)) ? bus_wdata[EV_W-1:0] : '0;
        r_d.evt  = (r_q.evt & ~ev_clr) | ev;
        if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    r_d.ctrl = '{lsb_first: bus_wdata[9], hold: bus_wdata[8],
                                 manual_sel: bus_wdata[7], cpha: bus_wdata[4],
                                 cpol: bus_wdata[3], master: bus_wdata[2],
                                 enable: bus_wdata[1], loop: bus_wdata[0]};
                    txq_clr = bus_wdata[5];
                    rxq_clr = bus_wdata[6];
                end
                OFS_SEL:  r_d.sel  = bus_wdata[NUM_SS-1:0];
                OFS_GATE: r_d.gate = bus_wdata[31];
                OFS_EVEN: r_d.en   = bus_wdata[EV_W-1:0];
                OFS_TXQ:  txq_push = 1'b1;
                OFS_KILL: kill     = (bus_wdata == KILL_KEY);
                default: ;
            endcase
        end
        if (kill) begin
            r_d     = REGS_INIT;
            txq_clr = 1'b1;
            rxq_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_INIT;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {22'd0, r_q.ctrl.lsb_first, r_q.ctrl.hold, r_q.ctrl.manual_sel,
                                   2'b00, r_q.ctrl.cpha, r_q.ctrl.cpol, r_q.ctrl.master,
                                   r_q.ctrl.enable, r_q.ctrl.loop};
            OFS_STAT: bus_rdata = {27'd0, 1'b0, txq_full, txq_empty, rxq_full, rxq_empty};
            OFS_RXQ:  bus_rdata = 32'(rxq_dout);
            OFS_SEL:  bus_rdata = 32'(r_q.sel);
            OFS_GATE: bus_rdata = {r_q.gate, 31'd0};
            OFS_EVT:  bus_rdata = 32'(r_q.evt);
            OFS_EVEN: bus_rdata = 32'(r_q.en);
            default:  bus_rdata = '0;
        endcase
    end

    spim_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clear(txq_clr), .push(txq_push),
        .din(bus_wdata[WORD_W-1:0]), .pop(sh_pop), .dout(txq_dout),
        .empty(txq_empty), .full(txq_full), .count(txq_cnt)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clear(rxq_clr), .push(sh_done),
        .din(sh_rx), .pop(rxq_pop), .dout(rxq_dout),
        .empty(rxq_empty), .full(rxq_full), .count(rxq_cnt)
    );

    spim_shifter #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_shf (
        .clk(clk), .rst_n(rst_n), .clear(kill), .allow(allow),
        .cpol(cpol_q), .cpha(r_q.ctrl.cpha), .lsb_first(r_q.ctrl.lsb_first),
        .loop(r_q.ctrl.loop), .tx_avail(!txq_empty), .tx_word(txq_dout),
        .tx_pop(sh_pop), .miso(miso), .sclk(sclk), .mosi(mosi),
        .busy(sh_busy), .word_done(sh_done), .rx_word(sh_rx)
    );

    assign irq  = r_q.gate && |(r_q.evt & r_q.en);
    assign ss_n = (manual_q || sh_busy) ? r_q.sel : '1;
endmodule

// File: rtl/spi_host_regs_chk.sv
module spi_host_regs_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [7:0]        addr,
    input logic [31:0]       wdata,
    input logic              busy,
    input logic              hold,
    input logic              cpol,
    input logic              manual,
    input logic              gate,
    input logic              irq,
    input logic              sclk,
    input logic [NUM_SS-1:0] ss_n,
    input logic              tx_empty,
    input logic              rx_empty
);
    p_hold_keeps_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !busy) |=> !busy);

    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    p_gate_blocks_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !irq);

    p_manual_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 8'h70 && manual) |=> (ss_n == $past(wdata[NUM_SS-1:0])));

    p_txq_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 8'h60 && wdata[5]) |=> tx_empty);

    p_rxq_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 8'h60 && wdata[6]) |=> rx_empty);

    p_kill_core_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 8'h40 && wdata == 32'h0A) |=> (!busy && !irq && tx_empty && rx_empty && hold));
endmodule

bind spi_host_regs spi_host_regs_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(sh_busy), .hold(hold_q), .cpol(cpol_q), .manual(manual_q),
    .gate(r_q.gate), .irq(irq), .sclk(sclk), .ss_n(ss_n),
    .tx_empty(txq_empty), .rx_empty(rxq_empty)
);

// File: tb/spi_host_regs_bench.sv
`timescale 1ns/1ps
module spi_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi, miso;
    logic [3:0]  ss_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_host_regs u_spi_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // bench-side slave on select 0
    logic       b_cpol = 0, b_cpha = 0, b_lsb = 0;
    logic [7:0] s_out = '0;
    logic [7:0] s_cap = '0;
    int         s_total = 0;
    int         s_base = 0;
    int         edges = 0;
    logic       mosi_d = 0;

    always @(negedge clk) mosi_d <= mosi;

    always @(sclk) begin
        if (rst_n) edges++;
        if (rst_n && !ss_n[0] && (((sclk != b_cpol) ? 1'b1 : 1'b0) ^ b_cpha)) begin
            s_cap = {s_cap[6:0], mosi_d};
            s_total++;
        end
    end

    always_comb begin
        int k;
        k = s_total - s_base;
        if (k >= 0 && k < 8) miso = b_lsb ? s_out[k] : s_out[7-k];
        else                 miso = 1'b0;
    end

    // cpol, cpha, lsb, tx word, slave word
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 1'b0, 8'h96, 8'hC3},
        {1'b1, 1'b0, 1'b0, 8'h1E, 8'h81},
        {1'b1, 1'b1, 1'b0, 8'h7F, 8'h01},
        {1'b0, 1'b0, 1'b1, 8'h12, 8'hF0},
        {1'b1, 1'b1, 1'b1, 8'hC8, 8'h5A}
    };

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h20, v);
            if (v[2]) return;
        end
        chk(tag, 32'd0, 32'd1);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        int e0, mism;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R6 reset state
        rd(8'h60, v); chk("R1 ctrl reset", v, 32'h180);
        rd(8'h64, v); chk("R6 status reset", v, 32'h05);
        rd(8'h70, v); chk("R1 select reset", v, 32'hF);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        chk("R1 sclk rest", {31'd0, sclk}, 32'd0);

        // R3 / R4 mode vectors with bench slave
        foreach (VEC[i]) begin
            base = 32'h086 | (32'(VEC[i][18]) << 3) | (32'(VEC[i][17]) << 4) | (32'(VEC[i][16]) << 9);
            wr(8'h60, base | 32'h100);
            b_cpol = VEC[i][18]; b_cpha = VEC[i][17]; b_lsb = VEC[i][16];
            s_out = VEC[i][7:0];
            s_base = s_total;
            wr(8'h70, 32'hE);
            wr(8'h68, 32'(VEC[i][15:8]));
            wr(8'h60, base);
            wait_done("R3 done timeout");
            rd(8'h6C, v);
            chk(VEC[i][16] ? "R4 lsb rx word" : "R3 rx word", v, 32'(VEC[i][7:0]));
            chk(VEC[i][16] ? "R4 lsb wire order" : "R3 wire capture", 32'(s_cap),
                32'(VEC[i][16] ? rev8(VEC[i][15:8]) : VEC[i][15:8]));
            wr(8'h70, 32'hF);
            wr(8'h20, 32'h7F);
        end

        // R2 hold, R5 loopback, R7 timing, R9 gating
        s_out = 8'hFF;
        wr(8'h60, 32'h187);
        wr(8'h28, 32'h04);
        wr(8'h1C, 32'h8000_0000);
        wr(8'h68, 32'h3C);
        e0 = edges;
        repeat (60) @(negedge clk);
        chk("R2 no edges while held", 32'(edges - e0), 32'd0);
        chk("R7 no done while held", {31'd0, irq}, 32'd0);
        wr(8'h60, 32'h087);
        wait (edges == e0 + 16);
        @(negedge clk);
        chk("R7 not before final edge+1", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 done one cycle after", {31'd0, irq}, 32'd1);
        chk("R2 edges per word", 32'(edges - e0), 32'd16);
        rd(8'h6C, v); chk("R5 loopback ignores miso", v, 32'h3C);
        wr(8'h1C, 32'h0);
        chk("R9 gate off", {31'd0, irq}, 32'd0);
        wr(8'h1C, 32'h8000_0000);
        chk("R9 gate on", {31'd0, irq}, 32'd1);
        wr(8'h20, 32'h04);
        chk("R9 clear by one", {31'd0, irq}, 32'd0);
        rd(8'h20, v); chk("R9 events cleared", v, 32'h0);

        // R8 / R13 queue limits and ordering
        wr(8'h60, 32'h187);
        for (int i = 0; i < 17; i++) wr(8'h68, 32'(i));
        rd(8'h20, v); chk("R8 tx drop flag", v & 32'h08, 32'h08);
        rd(8'h64, v); chk("R6 tx full", v & 32'h0F, 32'h09);
        wr(8'h60, 32'h087);
        wait_done("R13 burst timeout");
        rd(8'h20, v); chk("R8 rx full and half flags", v & 32'h50, 32'h50);
        rd(8'h64, v); chk("R6 rx full", v & 32'h0F, 32'h06);
        wr(8'h20, 32'h7F);
        wr(8'h68, 32'h77);
        wait_done("R8 overrun timeout");
        rd(8'h20, v); chk("R8 rx drop flag", v & 32'h20, 32'h20);
        mism = 0;
        for (int i = 0; i < 16; i++) begin
            rd(8'h6C, v);
            if (v != 32'(i)) mism++;
        end
        chk("R13 order", 32'(mism), 32'd0);
        rd(8'h64, v); chk("R6 rx empty", v & 32'h01, 32'h01);
        wr(8'h20, 32'h7F);

        // R11 queue flush
        wr(8'h60, 32'h187);
        wr(8'h68, 32'h01);
        wr(8'h68, 32'h02);
        rd(8'h64, v); chk("R11 tx loaded", v & 32'h04, 32'h00);
        wr(8'h60, 32'h1A7);
        rd(8'h64, v); chk("R11 tx flushed", v & 32'h04, 32'h04);
        rd(8'h60, v); chk("R11 flush bits read zero", v, 32'h187);
        wr(8'h68, 32'h11);
        wr(8'h60, 32'h087);
        wait_done("R11 word timeout");
        rd(8'h64, v); chk("R11 rx holds word", v & 32'h01, 32'h00);
        wr(8'h60, 32'h0C7);
        rd(8'h64, v); chk("R11 rx flushed", v & 32'h01, 32'h01);
        wr(8'h20, 32'h7F);

        // R10 automatic select
        wr(8'h60, 32'h006);
        wr(8'h70, 32'hD);
        chk("R10 auto idle deselect", 32'(ss_n), 32'hF);
        e0 = edges;
        wr(8'h68, 32'h55);
        wait (edges == e0 + 4);
        @(negedge clk);
        chk("R10 auto select in flight", 32'(ss_n), 32'hD);
        wait_done("R10 word timeout");
        chk("R10 auto release", 32'(ss_n), 32'hF);
        wr(8'h60, 32'h086);
        chk("R10 manual drive", 32'(ss_n), 32'hD);

        // R12 core reset key
        wr(8'h40, 32'h05);
        rd(8'h60, v); chk("R12 wrong key ignored", v, 32'h086);
        wr(8'h40, 32'h0A);
        rd(8'h60, v); chk("R12 ctrl after key", v, 32'h180);
        rd(8'h70, v); chk("R12 select after key", v, 32'hF);
        rd(8'h64, v); chk("R12 status after key", v, 32'h05);
        rd(8'h1C, v); chk("R12 gate after key", v, 32'h0);

        summary();
    end
endmodule